// File: doc/BRIEF.md
# Fully Associative Byte Cache with True LRU Replacement

This block is a small cache between a requester that issues single-byte reads and writes and a main memory that supplies whole blocks. The byte address space is 64 bytes. The cache holds four blocks of four bytes each. There is no index field, so any block may sit in any slot. On every request the tags of all valid slots are compared at once, and a valid slot with an equal tag is a hit.

A read miss stalls the requester. The cache fetches the whole 4-byte block from memory, stores it in a slot and then returns the requested byte. The slot chosen is the lowest-numbered empty slot. When no slot is empty, the least recently used slot is replaced. Writes always go through to memory. A write that hits also updates the cached byte. A write that misses leaves the cache untouched.

Top module: `fa_lru_cache`

## Requirements
- R1: After reset every slot is invalid, `reqReady` is 1 and `respValid` is 0, so the first read of any address after reset is a miss.
- R2: The address splits into tag `reqAddr[5:2]` and byte offset `reqAddr[1:0]`. A request is accepted on a rising edge where `reqValid` and `reqReady` are both 1. An accepted read that hits raises `respValid` for one cycle on the next edge, with `respHit`=1 and `respRdata` equal to byte `offset` of the cached block.
- R3: A tag is present in at most one valid slot, so at most one slot matches a lookup.
- R4: Each slot carries a 2-bit recency rank (0 = most recent). The four ranks always form a permutation of 0 to 3. A hit or a fill makes the slot rank 0 and ages every slot that was more recent than it.
- R5: A read miss fills the lowest-numbered invalid slot. When all slots are valid, it replaces the slot whose rank is 3.
- R6: An accepted read miss raises `memRead` for one cycle on the next edge, with `memAddr` = {tag, 2'b00}. `reqReady` then stays 0 until `memRvalid` is sampled high. On that edge the 32-bit `memRdata` (byte k in bits 8k+7:8k) is stored. On the following edge `respValid` rises with `respHit`=0 and the requested byte.
- R7: Every accepted write raises `memWrite` for one cycle on the next edge, with `memAddr` = `reqAddr` and `memWdata` = `reqWdata`. On the same edge `respValid` rises, with `respHit` reporting the lookup result.
- R8: A write hit replaces the addressed cached byte and refreshes that slot's rank. A write miss neither allocates a slot nor changes any rank.
- R9: From a cold cache, reads of 0, 2, 2, 0, 16, 20, 8, 4 give miss, hit, hit, hit, miss, miss, miss, miss. The last of these evicts the block at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 6 | Byte address |
| reqWdata | input | 8 | Write byte |
| reqReady | output | 1 | Cache can accept a request (low while a refill is pending) |
| respValid | output | 1 | One-cycle response strobe |
| respHit | output | 1 | Lookup result of the answered request |
| respRdata | output | 8 | Read byte (meaningful for reads) |
| memRead | output | 1 | One-cycle block fetch request |
| memWrite | output | 1 | One-cycle byte write to memory |
| memAddr | output | 6 | Block address for fetch, byte address for write |
| memWdata | output | 8 | Byte written to memory |
| memRvalid | input | 1 | Fetched block is present on memRdata |
| memRdata | input | 32 | Fetched block, byte 0 in the low bits |

## Verification
The main function is tried with four kinds of stimulus. The first is the cold-start sequence, which shows how compulsory misses fill the empty slots in order. The second is a run where a hit refreshes an old block just before an eviction, which separates true LRU replacement from simple fill-order (FIFO) replacement. The third is a write miss followed by a read of the same address, which separates no-allocate from allocate-on-write. The last is a reset in the middle of the run, followed by a read of a block that was resident, which shows that every valid bit is cleared. Every read is compared against a shadow copy of memory that includes the bytes written so far. Fetch addresses, write-through pulses and stall length are checked for each access.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
  localparam int DEF_ADDR_W = 6;
  localparam int DEF_OFFS_W = 2;
  localparam int DEF_SLOTS  = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;     // capture the accepted request's offset
    logic touch;        // accepted request hit: refresh recency
    logic writeByte;    // write hit: update cached byte
    logic respCapture;  // load response regs from lookup
    logic fillLine;     // refill data arrived: install block
  } dpStrobe_t;
endpackage

// File: rtl/lru_rank.sv
module lru_rank #(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              touchEn,
  input  logic [SLOT_W-1:0] touchSlot,
  output logic [SLOT_W-1:0] lruSlot
);
  logic [SLOT_W-1:0] rank [SLOTS];
  logic [SLOTS-1:0]  rankMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) rank[i] <= SLOT_W'(i);
    end else if (touchEn) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (SLOT_W'(i) == touchSlot) rank[i] <= '0;
        else if (rank[i] < rank[touchSlot]) rank[i] <= rank[i] + 1'b1;
      end
    end
  end

  always_comb begin
    lruSlot = '0;
    for (int i = 0; i < SLOTS; i++)
      if (rank[i] == SLOT_W'(SLOTS - 1)) lruSlot = SLOT_W'(i);
  end

  always_comb begin
    rankMask = '0;
    for (int i = 0; i < SLOTS; i++) rankMask[rank[i]] = 1'b1;
  end

  // R4
  rank_perm_chk: assert property (@(posedge clk) disable iff (!rstN)
    rankMask == {SLOTS{1'b1}});
endmodule

// File: rtl/cache_dp.sv
module cache_dp
  import fa_cache_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int OFFS_W = DEF_OFFS_W,
  parameter int SLOTS  = DEF_SLOTS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strb,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [7:0]             reqWdata,
  input  logic [(8<<OFFS_W)-1:0] memRdata,
  output logic                   lookupHit,
  output logic                   respHit,
  output logic [7:0]             respRdata
);
  localparam int TAG_W  = ADDR_W - OFFS_W;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int LINE_W = 8 << OFFS_W;

  logic [SLOTS-1:0]  valid;
  logic [TAG_W-1:0]  tagQ  [SLOTS];
  logic [LINE_W-1:0] lineQ [SLOTS];
  logic [OFFS_W-1:0] pendOffs;
  logic [TAG_W-1:0]  pendTag;
  logic [SLOTS-1:0]  hitVec;
  logic [SLOT_W-1:0] hitSlot, victim, lruSlot, touchSlot;
  logic              anyFree;

  wire [TAG_W-1:0]  reqTag  = reqAddr[ADDR_W-1:OFFS_W];
  wire [OFFS_W-1:0] reqOffs = reqAddr[OFFS_W-1:0];

  // parallel tag compare
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign hitVec[g] = valid[g] && (tagQ[g] == reqTag);
  end
  assign lookupHit = |hitVec;

  always_comb begin
    hitSlot = '0;
    for (int i = 0; i < SLOTS; i++)
      if (hitVec[i]) hitSlot = SLOT_W'(i);
  end

  // victim: lowest empty slot, else least recent
  always_comb begin
    victim  = '0;
    anyFree = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (!valid[i]) begin
        victim  = SLOT_W'(i);
        anyFree = 1'b1;
      end
    if (!anyFree) victim = lruSlot;
  end

  assign touchSlot = strb.fillLine ? victim : hitSlot;

  lru_rank #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_lru (
    .clk      (clk),
    .rstN     (rstN),
    .touchEn  (strb.touch | strb.fillLine),
    .touchSlot(touchSlot),
    .lruSlot  (lruSlot)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid    <= '0;
      pendOffs <= '0;
      pendTag  <= '0;
    end else begin
      if (strb.latchReq) begin
        pendOffs <= reqOffs;
        pendTag  <= reqTag;
      end
      if (strb.fillLine) begin
        valid[victim] <= 1'b1;
        tagQ[victim]  <= pendTag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fillLine) lineQ[victim] <= memRdata;
    else if (strb.writeByte) lineQ[hitSlot][8*reqOffs +: 8] <= reqWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respHit   <= 1'b0;
      respRdata <= '0;
    end else if (strb.fillLine) begin
      respHit   <= 1'b0;
      respRdata <= memRdata[8*pendOffs +: 8];
    end else if (strb.respCapture) begin
      respHit   <= lookupHit;
      respRdata <= lineQ[hitSlot][8*reqOffs +: 8];
    end
  end

  // R3
  one_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));
  // R5
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillLine |=> valid[$past(victim)]);
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import fa_cache_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int OFFS_W = DEF_OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqWdata,
  input  logic              lookupHit,
  input  logic              memRvalid,
  output dpStrobe_t         strb,
  output logic              reqReady,
  output logic              respValid,
  output logic              memRead,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata
);
  typedef enum logic {ST_IDLE, ST_FILL} ctrlState_t;
  ctrlState_t state;

  logic accept, readMiss, fillDone;
  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign readMiss = accept && !reqWrite && !lookupHit;
  assign fillDone = (state == ST_FILL) && memRvalid;

  always_comb begin
    strb             = '0;
    strb.latchReq    = accept;
    strb.touch       = accept && lookupHit;
    strb.writeByte   = accept && reqWrite && lookupHit;
    strb.respCapture = accept && (reqWrite || lookupHit);
    strb.fillLine    = fillDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      respValid <= 1'b0;
      memRead   <= 1'b0;
      memWrite  <= 1'b0;
      memAddr   <= '0;
      memWdata  <= '0;
    end else begin
      respValid <= strb.respCapture || fillDone;
      memRead   <= readMiss;
      memWrite  <= accept && reqWrite;
      if (accept) begin
        memAddr  <= reqWrite ? reqAddr
                             : {reqAddr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
        memWdata <= reqWdata;
      end
      if (readMiss) state <= ST_FILL;
      else if (fillDone) state <= ST_IDLE;
    end
  end

  // R6
  miss_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite && !lookupHit) |=> (memRead && !reqReady));
  // R6
  fill_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && memRvalid) |=> (respValid && reqReady));
  // R7
  write_thru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> (memWrite && respValid && memAddr == $past(reqAddr)));
endmodule

// File: rtl/fa_lru_cache.sv
module fa_lru_cache
  import fa_cache_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int OFFS_W = DEF_OFFS_W,
  parameter int SLOTS  = DEF_SLOTS,
  localparam int LINE_W = 8 << OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqWdata,
  output logic              reqReady,
  output logic              respValid,
  output logic              respHit,
  output logic [7:0]        respRdata,
  output logic              memRead,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic              memRvalid,
  input  logic [LINE_W-1:0] memRdata
);
  dpStrobe_t strb;
  logic      lookupHit;

  cache_ctrl #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .lookupHit(lookupHit), .memRvalid(memRvalid),
    .strb(strb), .reqReady(reqReady), .respValid(respValid),
    .memRead(memRead), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata)
  );

  cache_dp #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .SLOTS(SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .memRdata(memRdata),
    .lookupHit(lookupHit), .respHit(respHit), .respRdata(respRdata)
  );
endmodule

// File: tb/sim_fa_lru_cache.sv
`timescale 1ns/1ps
module sim_fa_lru_cache;
  logic       clk = 0, rstN = 0;
  logic       reqValid = 0, reqWrite = 0;
  logic [5:0] reqAddr = 0;
  logic [7:0] reqWdata = 0;
  logic       reqReady, respValid, respHit, memRead, memWrite;
  logic [7:0] respRdata, memWdata;
  logic [5:0] memAddr;
  logic       memRvalid = 0;
  logic [31:0] memRdata = 0;

  always #2.5 clk = ~clk;

  fa_lru_cache u0 (.*);

  logic [7:0] bmem [64];   // memory model
  logic [7:0] smem [64];   // expected memory contents
  int nChecks = 0, nFails = 0, fetches = 0, writes = 0;
  logic [5:0] fetchAddr, wrAddr;
  logic [7:0] wrData;
  bit done = 0;

  // vector: {write, addr, wdata, expHit}
  localparam int NV = 19;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 6'd0,  8'h00, 1'b0}, {1'b0, 6'd2,  8'h00, 1'b1},
    {1'b0, 6'd2,  8'h00, 1'b1}, {1'b0, 6'd0,  8'h00, 1'b1},
    {1'b0, 6'd16, 8'h00, 1'b0}, {1'b0, 6'd20, 8'h00, 1'b0},
    {1'b0, 6'd8,  8'h00, 1'b0}, {1'b0, 6'd4,  8'h00, 1'b0},
    {1'b0, 6'd17, 8'h00, 1'b1}, {1'b0, 6'd0,  8'h00, 1'b0},
    {1'b0, 6'd20, 8'h00, 1'b0}, {1'b0, 6'd11, 8'h00, 1'b0},
    {1'b1, 6'd1,  8'hA5, 1'b1}, {1'b0, 6'd1,  8'h00, 1'b1},
    {1'b1, 6'd60, 8'h3C, 1'b0}, {1'b0, 6'd60, 8'h00, 1'b0},
    {1'b0, 6'd5,  8'h00, 1'b0}, {1'b0, 6'd22, 8'h00, 1'b0},
    {1'b0, 6'd3,  8'h00, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    for (int i = 0; i < 64; i++) begin
      bmem[i] = 8'((i * 37 + 11) & 255);
      smem[i] = bmem[i];
    end
    forever begin
      @(negedge clk);
      if (memWrite) begin
        bmem[memAddr] = memWdata;
        wrAddr = memAddr; wrData = memWdata; writes++;
      end
      if (memRead) begin
        fetches++;
        fetchAddr = memAddr;
        @(negedge clk);
        memRvalid = 1;
        memRdata = {bmem[{fetchAddr[5:2], 2'd3}], bmem[{fetchAddr[5:2], 2'd2}],
                    bmem[{fetchAddr[5:2], 2'd1}], bmem[{fetchAddr[5:2], 2'd0}]};
        @(negedge clk);
        memRvalid = 0;
      end
    end
  end

  task automatic doAccess(input bit w, input logic [5:0] a, input logic [7:0] d,
                          input bit expHit, input string req);
    int f0, w0, waitN;
    bit stallOk;
    @(negedge clk);
    chk(reqReady == 1'b1, "R6", "ready before request", reqReady, 1);
    f0 = fetches; w0 = writes;
    reqValid = 1; reqWrite = w; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 0;
    waitN = 0; stallOk = 1;
    while (!respValid && waitN < 10) begin
      if (reqReady) stallOk = 0;
      @(negedge clk);
      waitN++;
    end
    #1;
    chk(respValid == 1'b1, req, "response present", respValid, 1);
    chk(respHit == expHit, req, $sformatf("hit flag addr %0d", a), respHit, expHit);
    if (w) begin
      smem[a] = d;
      chk(writes == w0 + 1 && wrAddr == a && wrData == d, "R7",
          $sformatf("write-through addr %0d data", a), wrData, d);
      chk(waitN == 0 && fetches == f0, "R7 R8", "write latency/no fetch", waitN, 0);
    end else begin
      chk(respRdata == smem[a], req, $sformatf("read data addr %0d", a), respRdata, smem[a]);
      if (expHit)
        chk(waitN == 0 && fetches == f0, "R2 R3", "hit latency/no fetch", waitN, 0);
      else begin
        chk(waitN == 2 && stallOk, "R6", "miss stall length", waitN, 2);
        chk(fetches == f0 + 1 && fetchAddr == {a[5:2], 2'b00}, "R6",
            "fetch block address", fetchAddr, {a[5:2], 2'b00});
      end
    end
    @(negedge clk);
    chk(respValid == 1'b0, req, "response one cycle", respValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
    chk(respValid == 1'b0, "R1", "respValid after reset", respValid, 0);
    chk(memRead == 1'b0 && memWrite == 1'b0, "R1", "memory strobes after reset", memRead, 0);

    for (int i = 0; i < NV; i++) begin
      string tagS;
      if (i < 8) tagS = "R9";
      else if (VEC[i][15]) tagS = "R8";
      else tagS = "R4 R5";
      doAccess(VEC[i][15], VEC[i][14:9], VEC[i][8:1], VEC[i][0], tagS);
    end

    // R1: reset mid-run clears valid bits; block 0 was resident
    @(negedge clk);
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(reqReady == 1'b1 && respValid == 1'b0, "R1", "state after second reset", reqReady, 1);
    doAccess(1'b0, 6'd3, 8'h00, 1'b0, "R1");
    doAccess(1'b0, 6'd3, 8'h00, 1'b1, "R2");
    // R8: write miss, then read still misses
    doAccess(1'b1, 6'd40, 8'h5A, 1'b0, "R8");
    doAccess(1'b0, 6'd40, 8'h00, 1'b0, "R8");
    doAccess(1'b1, 6'd42, 8'hC3, 1'b1, "R8");
    doAccess(1'b0, 6'd42, 8'h00, 1'b1, "R8");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule